// File: doc/BRIEF.md
# Message-Signalled Interrupt Issuer with Pending Replay

This block converts interrupt requests, each naming a vector number, into single 32-bit memory write transactions toward a programmed message address. The address, the 16-bit message data, the enabled-vector-count field, the per-vector mask and the enable bit arrive as live levels from a neighbouring capability register file. A one-cycle pulse from that register file marks every configuration write.

When per-vector masking is built in (`MASK_EN`), a request for a masked vector is not sent. Instead it sets that vector's bit in a pending register, which is visible on an output. After each configuration write made while the block is enabled, two things happen in order. First, pending bits at or above the current vector count are discarded. Then a scan walks the vectors from 0 upward and sends one write for every vector that is still pending and now unmasked.

Only one write is in flight at a time. Direct requests are held off through `req_ready` while a write waits for `mw_ready` and while a replay scan is queued or running. The legacy level interrupt request is passed through only while message mode is off.

Top module: `msi_issuer`

## Requirements
- R1: An accepted request (`req_valid` and `req_ready` high at a clock edge), with the enable bit set, a vector inside the enabled count and the vector unmasked, raises `mw_valid` in the next cycle. `mw_addr` equals `cfg_addr` with bits [1:0] forced to zero.
- R2: `mw_data` bits [31:16] are zero and bits [15:0] are `cfg_data`. When the effective count exceeds one, the low log2(count) bits of `cfg_data` are replaced by the vector number.
- R3: With `MASK_EN`=1, an accepted in-range request whose `cfg_mask` bit is 1 sets bit [vector] of `pending` in the next cycle and issues no write.
- R4: The effective count is 2 to the power min(`cfg_count_log2`, `MAX_LOG2`). A request with vector at or above that count is accepted and discarded: no write is issued and `pending` does not change.
- R5: While `cfg_enable` is 0, requests are accepted and discarded, no new write starts, and `pending` does not change.
- R6: `intx_out` equals `intx_in` while `cfg_enable` is 0, and is 0 while `cfg_enable` is 1.
- R7: A `cfg_wr` pulse seen while `cfg_enable` is 1 clears every `pending` bit at or above the effective count by the next cycle.
- R8: After such a pulse, each pending vector whose mask bit is 0 is sent, one write each, in ascending vector order. Its pending bit is cleared when its write starts. Masked pending vectors stay pending.
- R9: While `mw_valid` is 1 and `mw_ready` is 0, `mw_valid`, `mw_addr` and `mw_data` hold steady. `req_ready` is 0 whenever `mw_valid` is 1.
- R10: With `MASK_EN`=0, `cfg_mask` has no effect: every in-range enabled request is written out, and `pending` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 5 | Vector number of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| cfg_enable | input | 1 | Message mode enable |
| cfg_count_log2 | input | 3 | log2 of the enabled vector count |
| cfg_addr | input | ADDR_W | Message address |
| cfg_data | input | 16 | Message data |
| cfg_mask | input | 2**MAX_LOG2 | Per-vector mask bits |
| cfg_wr | input | 1 | Pulse marking a configuration write |
| intx_in | input | 1 | Legacy interrupt request from the function |
| intx_out | output | 1 | Legacy interrupt request after gating |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | ADDR_W | Memory write address |
| mw_data | output | 32 | Memory write data, little-endian word |
| pending | output | 2**MAX_LOG2 | Pending vector bits |

## Verification
The bench goes after the following corner cases, and what a faulty design would do in each:
- Data substitution at count 1 and at the clamped count. A design that substituted at count 1 would alter bit 0 of the message data; one that skipped the clamp would reject vector 31 when the count field reads 7.
- A vector just outside the count. A faulty design would write it out or mark it pending.
- A replay where out-of-range pending bits must be cut before the scan. Missing this would send a write for a vector the count no longer covers.
- A replay with several unmasked pending vectors. A faulty design would send them out of ascending order, send one twice, or leave its bit set.
- A write stalled by `mw_ready`. A faulty design would let its data drift or accept a new request meanwhile.
- Random mixes of counts, masks and requests, compared against a bench model of the pending register.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int VEC_W = 5;
    localparam int CNT_W = 3;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Limit the programmed count exponent to what the block was built for.
    function automatic cnt_t clamp_log2(input cnt_t field, input int unsigned limit);
        if (32'(field) > limit) begin
            return cnt_t'(limit);
        end
        return field;
    endfunction
endpackage

// File: rtl/msi_vec_range.sv
module msi_vec_range
    import msi_pkg::*;
#(
    parameter int MAX_LOG2 = 5,
    parameter int NVEC     = 1 << MAX_LOG2
) (
    input  cnt_t            cfg_count_log2,
    input  vec_t            probe_vec,
    output cnt_t            eff_log2,
    output logic [5:0]      vec_count,
    output logic [NVEC-1:0] live_mask,
    output logic            probe_ok
);
    assign eff_log2  = clamp_log2(cfg_count_log2, MAX_LOG2);
    assign vec_count = 6'd1 << eff_log2;
    assign probe_ok  = ({1'b0, probe_vec} < vec_count);

    for (genvar gi = 0; gi < NVEC; gi++) begin : g_live
        assign live_mask[gi] = (6'(gi) < vec_count);
    end
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt
    import msi_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [15:0]       base_data,
    input  cnt_t              eff_log2,
    input  vec_t              vec,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data
);
    logic [15:0] low_bits;

    assign low_bits = (16'd1 << eff_log2) - 16'd1;
    assign wr_addr  = {base_addr[ADDR_W-1:2], 2'b00};
    assign wr_data  = {16'h0000, (base_data & ~low_bits) | (16'(vec) & low_bits)};
endmodule

// File: rtl/msi_issuer.sv
module msi_issuer
    import msi_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int MAX_LOG2 = 5,
    parameter bit MASK_EN  = 1'b1,
    localparam int NVEC    = 1 << MAX_LOG2,
    localparam int VW      = (MAX_LOG2 > 0) ? MAX_LOG2 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_vector,
    output logic              req_ready,
    input  logic              cfg_enable,
    input  logic [2:0]        cfg_count_log2,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_data,
    input  logic [NVEC-1:0]   cfg_mask,
    input  logic              cfg_wr,
    input  logic              intx_in,
    output logic              intx_out,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [31:0]       mw_data,
    output logic [NVEC-1:0]   pending
);
    typedef struct packed {
        logic              mw_valid;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [NVEC-1:0]   pend;
        logic              scan_req;
        logic              scan_act;
        vec_t              idx;
    } state_t;

    state_t s_q, s_d;

    cnt_t              eff_log2;
    logic [5:0]        vec_count;
    logic [NVEC-1:0]   live_mask;
    logic              req_in_range;
    vec_t              issue_vec;
    logic [ADDR_W-1:0] fmt_addr;
    logic [31:0]       fmt_data;
    logic              accept;
    logic              req_masked;
    logic              scan_hit;
    logic [5:0]        next_pos;

    msi_vec_range #(
        .MAX_LOG2(MAX_LOG2),
        .NVEC    (NVEC)
    ) u_range (
        .cfg_count_log2(cfg_count_log2),
        .probe_vec     (req_vector),
        .eff_log2      (eff_log2),
        .vec_count     (vec_count),
        .live_mask     (live_mask),
        .probe_ok      (req_in_range)
    );

    assign issue_vec = s_q.scan_act ? s_q.idx : req_vector;

    msi_msg_fmt #(
        .ADDR_W(ADDR_W)
    ) u_fmt (
        .base_addr(cfg_addr),
        .base_data(cfg_data),
        .eff_log2 (eff_log2),
        .vec      (issue_vec),
        .wr_addr  (fmt_addr),
        .wr_data  (fmt_data)
    );

    assign req_ready  = !s_q.mw_valid && !s_q.scan_req && !s_q.scan_act;
    assign accept     = req_valid && req_ready;
    assign req_masked = MASK_EN && cfg_mask[req_vector[VW-1:0]];
    assign scan_hit   = s_q.pend[s_q.idx[VW-1:0]] && !(MASK_EN && cfg_mask[s_q.idx[VW-1:0]]);
    assign next_pos   = {1'b0, s_q.idx} + 6'd1;

    always_comb begin
        s_d = s_q;

        // completion of the outstanding write
        if (s_q.mw_valid && mw_ready) begin
            s_d.mw_valid = 1'b0;
        end

        // direct request path
        if (accept && cfg_enable && req_in_range) begin
            if (req_masked) begin
                s_d.pend[req_vector[VW-1:0]] = 1'b1;
            end else begin
                s_d.mw_valid = 1'b1;
                s_d.addr     = fmt_addr;
                s_d.data     = fmt_data;
            end
        end

        // replay scan
        if (s_q.scan_act) begin
            if (!cfg_enable) begin
                s_d.scan_act = 1'b0;
            end else if (!s_q.mw_valid) begin
                if (scan_hit) begin
                    s_d.pend[s_q.idx[VW-1:0]] = 1'b0;
                    s_d.mw_valid = 1'b1;
                    s_d.addr     = fmt_addr;
                    s_d.data     = fmt_data;
                end
                if (next_pos >= vec_count) begin
                    s_d.scan_act = 1'b0;
                end else begin
                    s_d.idx = next_pos[VEC_W-1:0];
                end
            end
        end else if (s_q.scan_req) begin
            if (!cfg_enable) begin
                s_d.scan_req = 1'b0;
            end else if (!s_q.mw_valid) begin
                s_d.scan_req = 1'b0;
                s_d.scan_act = 1'b1;
                s_d.idx      = '0;
            end
        end

        // configuration write: trim pending and queue a replay scan
        if (cfg_wr && cfg_enable) begin
            s_d.pend     = s_d.pend & live_mask;
            s_d.scan_req = 1'b1;
        end

        if (!MASK_EN) begin
            s_d.pend = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mw_valid = s_q.mw_valid;
    assign mw_addr  = s_q.addr;
    assign mw_data  = s_q.data;
    assign pending  = s_q.pend;
    assign intx_out = intx_in && !cfg_enable;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data))); // R9

    AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> !req_ready); // R9

    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !mw_valid) |=> !mw_valid); // R5

    AST_MASKED_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_enable && req_in_range && req_masked) |=> !mw_valid); // R3

    AST_PEND_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_enable) |=> ((pending & ~$past(live_mask)) == '0)); // R7
endmodule

// File: tb/msi_issuer_test.sv
module msi_issuer_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 64;
    localparam int NV = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [4:0] req_vector = '0;
    logic req_ready, req_ready_nm;
    logic cfg_enable = 1'b0;
    logic [2:0] cfg_count_log2 = '0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic [NV-1:0] cfg_mask = '0;
    logic cfg_wr = 1'b0;
    logic intx_in = 1'b0;
    logic intx_out, intx_out_nm;
    logic mw_valid, mw_valid_nm;
    logic mw_ready = 1'b0;
    logic [ADDR_W-1:0] mw_addr, mw_addr_nm;
    logic [31:0] mw_data, mw_data_nm;
    logic [NV-1:0] pending, pending_nm;

    int tests = 0;
    int fails = 0;
    int nm_writes = 0;
    logic [NV-1:0] pend_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_issuer #(.ADDR_W(ADDR_W), .MAX_LOG2(5), .MASK_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_ready(req_ready), .cfg_enable(cfg_enable), .cfg_count_log2(cfg_count_log2),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_wr(cfg_wr),
        .intx_in(intx_in), .intx_out(intx_out), .mw_valid(mw_valid), .mw_ready(mw_ready),
        .mw_addr(mw_addr), .mw_data(mw_data), .pending(pending));

    msi_issuer #(.ADDR_W(ADDR_W), .MAX_LOG2(5), .MASK_EN(1'b0)) u_nomask (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_ready(req_ready_nm), .cfg_enable(cfg_enable), .cfg_count_log2(cfg_count_log2),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_wr(cfg_wr),
        .intx_in(intx_in), .intx_out(intx_out_nm), .mw_valid(mw_valid_nm), .mw_ready(1'b1),
        .mw_addr(mw_addr_nm), .mw_data(mw_data_nm), .pending(pending_nm));

    always @(posedge clk) if (rst_n && mw_valid_nm) nm_writes <= nm_writes + 1;

    function automatic int eff_count(input logic [2:0] lg);
        return 1 << ((lg > 3'd5) ? 5 : int'(lg));
    endfunction

    function automatic logic [31:0] exp_data(input logic [15:0] d, input logic [2:0] lg, input int v);
        logic [15:0] lowm;
        lowm = 16'(eff_count(lg) - 1);
        return {16'h0000, (d & ~lowm) | (16'(v) & lowm)};
    endfunction

    function automatic logic [NV-1:0] range_mask(input logic [2:0] lg);
        logic [NV-1:0] m;
        for (int i = 0; i < NV; i++) m[i] = (i < eff_count(lg));
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input int v);
        int n = 0;
        @(negedge clk);
        while (!req_ready && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_vector = 5'(v);
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic expect_write(input int v, input string tag);
        int n = 0;
        @(negedge clk);
        while (!mw_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(mw_valid, {tag, " valid"}, 64'(mw_valid), 64'd1);
        check(mw_data == exp_data(cfg_data, cfg_count_log2, v), {tag, " data"},
              64'(mw_data), 64'(exp_data(cfg_data, cfg_count_log2, v)));
        check(mw_addr == (cfg_addr & ~64'h3), {tag, " addr"}, mw_addr, cfg_addr & ~64'h3);
        mw_ready = 1'b1;
        @(posedge clk);
        #1 mw_ready = 1'b0;
    endtask

    task automatic expect_none(input int cycles, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (mw_valid) seen = 1'b1;
        end
        check(!seen, tag, 64'(seen), 64'd0);
        if (seen) begin
            mw_ready = 1'b1;
            @(posedge clk);
            #1 mw_ready = 1'b0;
        end
    endtask

    task automatic pulse_cfg();
        @(negedge clk);
        cfg_wr = 1'b1;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
    endtask

    task automatic replay_and_check(input string tag);
        pulse_cfg();
        if (cfg_enable) begin
            pend_m = pend_m & range_mask(cfg_count_log2);
            for (int v = 0; v < NV; v++) begin
                if (pend_m[v] && !cfg_mask[v]) begin
                    expect_write(v, {tag, " R8 replay"});
                    pend_m[v] = 1'b0;
                end
            end
        end
        expect_none(40, {tag, " R8 no extra replay"});
        check(pending == pend_m, {tag, " R7 pending"}, 64'(pending), 64'(pend_m));
    endtask

    task automatic request_and_check(input int v, input string tag);
        do_req(v);
        if (cfg_enable && v < eff_count(cfg_count_log2)) begin
            if (cfg_mask[v]) begin
                pend_m[v] = 1'b1;
                expect_none(3, {tag, " R3 masked no write"});
            end else begin
                expect_write(v, {tag, " R1 R2 write"});
            end
        end else begin
            expect_none(3, {tag, " R4 R5 dropped"});
        end
        check(pending == pend_m, {tag, " R3 pending"}, 64'(pending), 64'(pend_m));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nm0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!mw_valid, "reset mw_valid", 64'(mw_valid), 64'd0);
        check(pending == '0, "reset pending", 64'(pending), 64'd0);
        check(req_ready, "reset req_ready", 64'(req_ready), 64'd1);

        // R6 legacy line gating
        intx_in = 1'b1;
        #1 check(intx_out == 1'b1, "R6 intx passes when disabled", 64'(intx_out), 64'd1);
        cfg_enable = 1'b1;
        #1 check(intx_out == 1'b0, "R6 intx forced low when enabled", 64'(intx_out), 64'd0);
        cfg_enable = 1'b0;
        intx_in = 1'b0;

        // R5 disabled drop
        cfg_addr = 64'h1234_5678_9ABC_DEF3;
        cfg_data = 16'hABCD;
        cfg_count_log2 = 3'd2;
        cfg_mask = 32'h0000_0002;
        request_and_check(0, "R5 disabled unmasked");
        request_and_check(1, "R5 disabled masked");

        cfg_enable = 1'b1;
        // R2 single vector keeps data unchanged
        cfg_count_log2 = 3'd0;
        request_and_check(0, "R2 count one");
        cfg_count_log2 = 3'd3;
        cfg_data = 16'hFFFF;
        cfg_mask = '0;
        request_and_check(5, "R2 count eight");
        // R4 out-of-range and clamp
        cfg_count_log2 = 3'd2;
        request_and_check(4, "R4 just outside");
        cfg_count_log2 = 3'd7;
        cfg_data = 16'h1240;
        request_and_check(31, "R4 clamped count");

        // R9 stall holds
        do_req(6);
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check(mw_valid && mw_data == exp_data(cfg_data, cfg_count_log2, 6),
                  "R9 held during stall", 64'(mw_data), 64'(exp_data(cfg_data, cfg_count_log2, 6)));
            check(!req_ready, "R9 req_ready low while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        expect_write(6, "R9 after stall");

        // R3 masked and R10 no-mask variant
        cfg_count_log2 = 3'd5;
        cfg_mask = 32'h0000_0208;
        nm0 = nm_writes;
        request_and_check(3, "R3 masked vector");
        repeat (3) @(negedge clk);
        check(nm_writes == nm0 + 1, "R10 mask ignored without support", 64'(nm_writes), 64'(nm0 + 1));
        check(pending_nm == '0, "R10 pending stays zero", 64'(pending_nm), 64'd0);

        // R7/R8 directed replay
        cfg_mask = 32'h0000_020C;
        request_and_check(2, "R8 setup 2");
        request_and_check(9, "R8 setup 9");
        cfg_count_log2 = 3'd3;
        cfg_mask = '0;
        replay_and_check("R7 R8 directed");

        // random mix
        for (int it = 0; it < 150; it++) begin
            if (($urandom % 10) < 7) begin
                request_and_check(int'($urandom % 32), "random req");
            end else begin
                cfg_count_log2 = 3'($urandom % 7);
                cfg_mask = ($urandom % 2) ? $urandom : ($urandom & $urandom);
                cfg_data = 16'($urandom);
                cfg_addr = {$urandom, $urandom};
                replay_and_check("random cfg");
            end
            check(pending_nm == '0, "R10 random pending zero", 64'(pending_nm), 64'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule